// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gate

This block sits between a host's active-low memory chip enable and up to four battery-backed SRAM banks. While the supply is good, a 2-bit bank select routes the host enable to one of four active-low bank enables. A digital power-fail flag from an outside comparator starts write protection. An access that is already under way may finish, but only within a write-protect timeout. After that, every bank enable is driven inactive. When the flag clears, the enables stay inactive for a recovery period so the host can settle. Only then may a new access start.

The chip enable, the select bits and the power-fail flag each pass through a two-flop synchronizer. One counter times both the grace window and the recovery window, and both lengths are parameters counted in clock cycles. A status output reports the phase of the sequence.

Top module: `pfce_gate`

## Requirements
- R1: In the normal state with `host_ce_n` low, `bank_ce_n[k]` is low for select code k (0 to 3) and the other three bits are high. Code 0 selects bit 0 and code 3 selects bit 3.
- R2: While `host_ce_n` is high, `bank_ce_n` is 4'b1111 for any select code.
- R3: If `pwr_fail` rises while no access is active, the block enters the protected state and `bank_ce_n` is 4'b1111.
- R4: If `pwr_fail` rises while `host_ce_n` is low, the block enters the draining state and the selected bank stays low. Once `host_ce_n` goes high, the block moves to the protected state.
- R5: A drain that is still active after `WP_CYC` clock cycles ends. The block enters the protected state with `bank_ce_n` at 4'b1111.
- R6: After `pwr_fail` falls, the block stays in the recovering state for exactly `REC_CYC` cycles with `bank_ce_n` at 4'b1111, then returns to normal.
- R7: In the protected and recovering states, toggling `host_ce_n` or `bank_sel` leaves `bank_ce_n` at 4'b1111.
- R8: Reset puts the block in the recovering state with `bank_ce_n` at 4'b1111. The block then counts a full `REC_CYC` window before it enters normal.
- R9: `seq_state` encodes the phase as 0 normal, 1 draining, 2 protected and 3 recovering.
- R10: A change on `host_ce_n` reaches `bank_ce_n` after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_ce_n | input | 1 | Host chip enable, active low |
| bank_sel | input | SEL_W | Bank select code |
| pwr_fail | input | 1 | Power-fail flag, active high |
| bank_ce_n | output | 2**SEL_W | Per-bank chip enables, active low |
| seq_state | output | 2 | Sequencer phase code |

## Verification
The bench drives the power flag at both edges of an access.

- **Clean start.** An access that begins just before the flag must complete cleanly. A design that cuts it short leaves no draining phase.
- **Grace window.** An access held past the window must be cut at exactly `WP_CYC` cycles. An off-by-one counter shows up as a drain length one cycle too long or too short.
- **Recovery window.** The recovery window is measured both after reset and after the flag clears. A design that leaks the host enable through during recovery shows a low bank bit in a phase that must be all high.
- **Routing and latency.** Random normal-mode traffic covers every select code with the enable both high and low, which exposes swapped decode bits. The synchronizer latency is checked edge by edge.

// File: rtl/pfce_pkg.sv
package pfce_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_PROT    = 2'd2,
    ST_RECOVER = 2'd3
  } pf_state_t;
endpackage

// File: rtl/pfce_sync.sv
module pfce_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pfce_seq.sv
module pfce_seq
  import pfce_pkg::*;
#(
  parameter int WP_CYC  = 1000,
  parameter int REC_CYC = 12_000_000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pf,
  input  logic      ce_n,
  output pf_state_t state,
  output logic      gate_en
);
  localparam int MAXC = (WP_CYC > REC_CYC) ? WP_CYC : REC_CYC;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] WP_LAST  = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] REC_LAST = CW'(REC_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RECOVER;
      cnt   <= '0;
    end else begin
      case (state)
        ST_NORMAL: begin
          cnt <= '0;
          if (pf) state <= ce_n ? ST_PROT : ST_DRAIN;
        end
        ST_DRAIN: begin
          if (ce_n || cnt == WP_LAST) begin
            state <= ST_PROT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PROT: begin
          cnt <= '0;
          if (!pf) state <= ST_RECOVER;
        end
        default: begin
          if (pf) begin
            state <= ST_PROT;
            cnt   <= '0;
          end else if (cnt == REC_LAST) begin
            state <= ST_NORMAL;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign gate_en = (state == ST_NORMAL) || (state == ST_DRAIN);
endmodule

// File: rtl/pfce_dec.sv
module pfce_dec #(
  parameter int SEL_W = 2,
  localparam int NB = 1 << SEL_W
) (
  input  logic             en,
  input  logic             ce_n,
  input  logic [SEL_W-1:0] sel,
  output logic [NB-1:0]    bank_n
);
  for (genvar i = 0; i < NB; i++) begin : g_bank
    assign bank_n[i] = !(en && !ce_n && (sel == SEL_W'(i)));
  end
endmodule

// File: rtl/pfce_gate.sv
module pfce_gate
  import pfce_pkg::*;
#(
  parameter int SEL_W   = 2,
  parameter int WP_CYC  = 1000,
  parameter int REC_CYC = 12_000_000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_ce_n,
  input  logic [SEL_W-1:0]        bank_sel,
  input  logic                    pwr_fail,
  output logic [(1<<SEL_W)-1:0]   bank_ce_n,
  output logic [1:0]              seq_state
);
  localparam int SW = SEL_W + 2;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, {SEL_W{1'b0}}};

  logic [SW-1:0]    sync_q;
  logic             pf_s, ce_n_s, gate_en;
  logic [SEL_W-1:0] sel_s;
  pf_state_t        state;

  pfce_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({pwr_fail, host_ce_n, bank_sel}), .q(sync_q)
  );

  assign pf_s   = sync_q[SW-1];
  assign ce_n_s = sync_q[SW-2];
  assign sel_s  = sync_q[SEL_W-1:0];

  pfce_seq #(.WP_CYC(WP_CYC), .REC_CYC(REC_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .pf(pf_s), .ce_n(ce_n_s),
    .state(state), .gate_en(gate_en)
  );

  pfce_dec #(.SEL_W(SEL_W)) u_dec (
    .en(gate_en), .ce_n(ce_n_s), .sel(sel_s), .bank_n(bank_ce_n)
  );

  assign seq_state = state;
endmodule

// File: rtl/pfce_gate_chk.sv
module pfce_gate_chk #(
  parameter int NB      = 4,
  parameter int WP_CYC  = 1000,
  parameter int REC_CYC = 12_000_000
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NB-1:0] bank_ce_n,
  input logic [1:0]    seq_state
);
  int drain_run, rec_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_run <= 0;
      rec_run   <= 0;
    end else begin
      drain_run <= (seq_state == 2'd1) ? drain_run + 1 : 0;
      rec_run   <= (seq_state == 2'd3) ? rec_run + 1 : 0;
    end
  end

  p_one_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~bank_ce_n) <= 1);
  p_prot_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state == 2'd2 |-> bank_ce_n == {NB{1'b1}});
  p_drain_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state == 2'd1 |-> drain_run < WP_CYC);
  p_rec_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state == 2'd3 |-> bank_ce_n == {NB{1'b1}});
  p_rec_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state == 2'd3 |-> rec_run < REC_CYC);
  p_prot_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state == 2'd2 |=> (seq_state == 2'd2 || seq_state == 2'd3));
  p_normal_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state == 2'd0 |=> seq_state != 2'd3);
endmodule

bind pfce_gate pfce_gate_chk #(.NB(1 << SEL_W), .WP_CYC(WP_CYC), .REC_CYC(REC_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_ce_n(bank_ce_n), .seq_state(seq_state)
);

// File: tb/pfce_gate_test.sv
module pfce_gate_test;
  localparam int WP  = 12;
  localparam int REC = 20;

  logic       clk = 1'b0;
  logic       rst_n, host_ce_n, pwr_fail;
  logic [1:0] bank_sel;
  logic [3:0] bank_ce_n;
  logic [1:0] seq_state;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  pfce_gate #(.SEL_W(2), .WP_CYC(WP), .REC_CYC(REC)) uut (
    .clk(clk), .rst_n(rst_n), .host_ce_n(host_ce_n), .bank_sel(bank_sel),
    .pwr_fail(pwr_fail), .bank_ce_n(bank_ce_n), .seq_state(seq_state)
  );

  function automatic logic [3:0] exp_banks(logic ce_n, logic [1:0] sel);
    return ce_n ? 4'hF : ~(4'b0001 << sel);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic count_state(input logic [1:0] st, output int n);
    n = 0;
    for (int i = 0; i < 1000 && seq_state == st; i++) begin
      n++;
      if (st == 2'd3 && bank_ce_n != 4'hF)
        check(0, "R7 enables off in recovery", bank_ce_n, 4'hF);
      step(1);
    end
  endtask

  task automatic wait_leave(input logic [1:0] st);
    for (int i = 0; i < 10 && seq_state == st; i++) step(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic c;
    logic [1:0] s;
    void'($urandom(1234));
    rst_n = 1'b0; host_ce_n = 1'b1; pwr_fail = 1'b0; bank_sel = 2'd0;
    step(3);
    check(seq_state == 2'd3, "R8 reset state", seq_state, 3);
    check(bank_ce_n == 4'hF, "R8 reset enables", bank_ce_n, 4'hF);
    host_ce_n = 1'b0; bank_sel = 2'd2;
    rst_n = 1'b1;
    count_state(2'd3, n);
    check(n == REC, "R8 recovery after reset", n, REC);
    check(bank_ce_n == 4'b1011, "R6 normal after recovery", bank_ce_n, 4'b1011);

    host_ce_n = 1'b1;
    step(3);
    host_ce_n = 1'b0; bank_sel = 2'd1;
    step(1);
    check(bank_ce_n == 4'hF, "R10 one edge no change", bank_ce_n, 4'hF);
    step(1);
    check(bank_ce_n == 4'b1101, "R10 two edges", bank_ce_n, 4'b1101);

    for (int i = 0; i < 200; i++) begin
      c = 1'($urandom_range(0, 1));
      s = 2'($urandom_range(0, 3));
      host_ce_n = c; bank_sel = s;
      step(2);
      check(bank_ce_n == exp_banks(c, s), c ? "R2 enable high" : "R1 decode",
            bank_ce_n, exp_banks(c, s));
      check(seq_state == 2'd0, "R9 normal code", seq_state, 0);
    end

    host_ce_n = 1'b1;
    step(3);
    pwr_fail = 1'b1;
    step(3);
    check(seq_state == 2'd2, "R3 protect idle", seq_state, 2);
    check(bank_ce_n == 4'hF, "R3 enables off", bank_ce_n, 4'hF);
    for (int i = 0; i < 6; i++) begin
      host_ce_n = 1'($urandom_range(0, 1));
      bank_sel = 2'($urandom_range(0, 3));
      step(3);
      check(bank_ce_n == 4'hF, "R7 toggle in protect", bank_ce_n, 4'hF);
    end
    host_ce_n = 1'b0; bank_sel = 2'd1;
    pwr_fail = 1'b0;
    wait_leave(2'd2);
    count_state(2'd3, n);
    check(n == REC, "R6 recovery length", n, REC);
    check(bank_ce_n == 4'b1101, "R6 access after recovery", bank_ce_n, 4'b1101);

    host_ce_n = 1'b0; bank_sel = 2'd3;
    step(3);
    pwr_fail = 1'b1;
    wait_leave(2'd0);
    check(seq_state == 2'd1, "R4 drain entered", seq_state, 1);
    check(bank_ce_n == 4'b0111, "R4 access kept", bank_ce_n, 4'b0111);
    step(3);
    check(bank_ce_n == 4'b0111, "R4 access still kept", bank_ce_n, 4'b0111);
    host_ce_n = 1'b1;
    step(3);
    check(seq_state == 2'd2, "R4 protect after end", seq_state, 2);
    check(bank_ce_n == 4'hF, "R4 enables off", bank_ce_n, 4'hF);
    host_ce_n = 1'b0;
    step(3);
    check(bank_ce_n == 4'hF, "R7 no new access", bank_ce_n, 4'hF);
    pwr_fail = 1'b0;
    wait_leave(2'd2);
    count_state(2'd3, n);
    check(n == REC, "R6 recovery length 2", n, REC);

    s = 2'($urandom_range(0, 3));
    host_ce_n = 1'b0; bank_sel = s;
    step(3);
    pwr_fail = 1'b1;
    wait_leave(2'd0);
    check(bank_ce_n == exp_banks(1'b0, s), "R4 drain keeps bank", bank_ce_n, exp_banks(1'b0, s));
    count_state(2'd1, n);
    check(n == WP, "R5 drain timeout", n, WP);
    check(seq_state == 2'd2, "R5 protect after timeout", seq_state, 2);
    check(bank_ce_n == 4'hF, "R5 enables off", bank_ce_n, 4'hF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule